// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block sits beside the execute stage of a small processor. A compare operation takes two register values and stores the result as three condition flags: equal, greater and less. The greater and less flags come from a signed comparison. The flags stay unchanged until the next compare, so any number of later jump operations can test them.

For a jump, the block receives a condition code, a base register value and a 16-bit offset. It reports in the same cycle whether the jump is taken. It also reports the target address, which is the base plus the sign-extended offset. A base of zero therefore gives an absolute address. Updating the program counter and flushing the pipeline belong to the surrounding core.

Top module: `branch_resolver`

## Requirements
- R1: On the clock edge where `cmp_valid` is high, the flags load the result of comparing `cmp_a` with `cmp_b`. From the next cycle, exactly one of `flag_eq`, `flag_gt` and `flag_lt` is high.
- R2: `flag_gt` and `flag_lt` compare the operands as signed two's-complement numbers. For example, 0xFFFFFFFF (-1) is less than 1, and 0x80000000 is less than 0x7FFFFFFF.
- R3: The flags keep their value until the next compare. Jump operations never modify them.
- R4: Synchronous active-high reset clears all three flags. With cleared flags, only condition codes 0 and 2 are taken.
- R5: `jmp_cond` selects the test applied to the flags:
  - 0: always taken
  - 1: equal
  - 2: not equal
  - 3: greater
  - 4: greater or equal (greater or equal flag set)
  - 5: less
  - 6: less or equal (less or equal flag set)
- R6: Condition code 7 is reserved, and such a jump is never taken.
- R7: `jmp_taken` is combinational from `jmp_valid`, `jmp_cond` and the stored flags. It is low whenever `jmp_valid` is low. A jump presented in the same cycle as a compare uses the flags from before that compare.
- R8: `jmp_target` equals `jmp_base` plus `jmp_off` sign-extended to 32 bits, modulo 2^32. With a zero base, the target is the sign-extended offset itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| jmp_valid | input | 1 | Jump strobe |
| jmp_cond | input | 3 | Condition code |
| jmp_base | input | 32 | Base register value |
| jmp_off | input | 16 | Signed offset |
| jmp_taken | output | 1 | Jump is taken |
| jmp_target | output | 32 | Computed jump target |
| flag_eq | output | 1 | Stored equal flag |
| flag_gt | output | 1 | Stored signed greater flag |
| flag_lt | output | 1 | Stored signed less flag |

## Verification
The bench builds the block with its defaults: 32-bit operands and addresses, and a 16-bit offset. At these widths it can reach the sign boundaries directly. Examples are the most negative value against the most positive one, an all-ones operand against one, and offsets of 0x7FFF and 0x8000. Every operand pair is tested against all eight condition codes. Wrap-around of the target at the top of the address space is also reached.

// File: rtl/brres_pkg.sv
package brres_pkg;

    localparam int CC_W = 3;

    typedef enum logic [CC_W-1:0] {
        CC_ALWAYS = 3'd0,
        CC_EQ     = 3'd1,
        CC_NE     = 3'd2,
        CC_GT     = 3'd3,
        CC_GE     = 3'd4,
        CC_LT     = 3'd5,
        CC_LE     = 3'd6,
        CC_RSVD   = 3'd7
    } cc_e;

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{eq: 1'b0, gt: 1'b0, lt: 1'b0};

    function automatic logic cond_met(flags_t f, cc_e cc);
        logic r;
        case (cc)
            CC_ALWAYS: r = 1'b1;
            CC_EQ:     r = f.eq;
            CC_NE:     r = !f.eq;
            CC_GT:     r = f.gt;
            CC_GE:     r = f.gt | f.eq;
            CC_LT:     r = f.lt;
            CC_LE:     r = f.lt | f.eq;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flag_latch.sv
module flag_latch
    import brres_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output flags_t            flags
);

    flags_t flags_q;
    flags_t flags_d;
    logic   run_q;

    always_comb begin
        flags_d.eq = (cmp_a == cmp_b);
        flags_d.gt = ($signed(cmp_a) > $signed(cmp_b));
        flags_d.lt = ($signed(cmp_a) < $signed(cmp_b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_CLEAR;
            run_q   <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (cmp_valid) begin
                flags_q <= flags_d;
            end
        end
    end

    assign flags = flags_q;

    // R1
    flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(cmp_valid)) |-> ($countones(flags_q) == 1));

    // R2
    signed_less_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(cmp_valid) && $past($signed(cmp_a) < $signed(cmp_b))) |-> flags_q.lt);

    // R3
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !$past(cmp_valid)) |-> $stable(flags_q));

    // R4
    flags_never_multi_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags_q));

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import brres_pkg::*;
(
    input  logic            jmp_valid,
    input  logic [CC_W-1:0] jmp_cond,
    input  flags_t          flags,
    output logic            taken
);

    cc_e cc;

    always_comb begin
        cc    = cc_e'(jmp_cond);
        taken = jmp_valid & cond_met(flags, cc);
    end

endmodule

// File: rtl/target_gen.sv
module target_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[ADDR_W-1:0];
        end
    endgenerate

    assign target = base + off_ext;

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brres_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              jmp_valid,
    input  logic [2:0]        jmp_cond,
    input  logic [DATA_W-1:0] jmp_base,
    input  logic [OFF_W-1:0]  jmp_off,
    output logic              jmp_taken,
    output logic [DATA_W-1:0] jmp_target,
    output logic              flag_eq,
    output logic              flag_gt,
    output logic              flag_lt
);

    flags_t flags;

    flag_latch #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .flags     (flags)
    );

    cond_eval u_cond (
        .jmp_valid (jmp_valid),
        .jmp_cond  (jmp_cond),
        .flags     (flags),
        .taken     (jmp_taken)
    );

    target_gen #(.ADDR_W(DATA_W), .OFF_W(OFF_W)) u_tgt (
        .base   (jmp_base),
        .off    (jmp_off),
        .target (jmp_target)
    );

    assign flag_eq = flags.eq;
    assign flag_gt = flags.gt;
    assign flag_lt = flags.lt;

    // R6
    rsvd_never_chk: assert property (@(posedge clk) disable iff (rst)
        (jmp_cond == 3'd7) |-> !jmp_taken);

    // R7
    idle_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        !jmp_valid |-> !jmp_taken);

    // R5
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && jmp_cond == 3'd0) |-> jmp_taken);

    // R5
    eq_ne_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && jmp_cond == 3'd2 && flag_eq) |-> !jmp_taken);

    // R8
    abs_target_chk: assert property (@(posedge clk) disable iff (rst)
        (jmp_base == '0) |-> (jmp_target[OFF_W-1:0] == jmp_off));

endmodule

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_valid;
    logic [31:0] cmp_a;
    logic [31:0] cmp_b;
    logic        jmp_valid;
    logic [2:0]  jmp_cond;
    logic [31:0] jmp_base;
    logic [15:0] jmp_off;
    logic        jmp_taken;
    logic [31:0] jmp_target;
    logic        flag_eq;
    logic        flag_gt;
    logic        flag_lt;

    int errors = 0;
    int checks = 0;

    // {a, b, expected {eq, gt, lt}}
    localparam logic [66:0] VEC [NVEC] = '{
        {32'd5,          32'd7,          3'b001},
        {32'd7,          32'd5,          3'b010},
        {32'd9,          32'd9,          3'b100},
        {32'hFFFF_FFFF,  32'd1,          3'b001},
        {32'h8000_0000,  32'h7FFF_FFFF,  3'b001},
        {32'd1,          32'hFFFF_FFFF,  3'b010},
        {32'h8000_0000,  32'h8000_0000,  3'b100}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_resolver dut (
        .clk        (clk),
        .rst        (rst),
        .cmp_valid  (cmp_valid),
        .cmp_a      (cmp_a),
        .cmp_b      (cmp_b),
        .jmp_valid  (jmp_valid),
        .jmp_cond   (jmp_cond),
        .jmp_base   (jmp_base),
        .jmp_off    (jmp_off),
        .jmp_taken  (jmp_taken),
        .jmp_target (jmp_target),
        .flag_eq    (flag_eq),
        .flag_gt    (flag_gt),
        .flag_lt    (flag_lt)
    );

    function automatic logic model_taken(logic [2:0] f, int cc);
        logic eq = f[2];
        logic gt = f[1];
        logic lt = f[0];
        case (cc)
            0: return 1'b1;
            1: return eq;
            2: return !eq;
            3: return gt;
            4: return gt | eq;
            5: return lt;
            6: return lt | eq;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_a     = a;
        cmp_b     = b;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic jump_check(input int cc, input logic exp, input string req);
        jmp_valid = 1'b1;
        jmp_cond  = cc[2:0];
        #1;
        check(jmp_taken === exp, req, {31'd0, jmp_taken}, {31'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0] f_saved;
        rst = 1'b1;
        cmp_valid = 1'b0;
        cmp_a = '0;
        cmp_b = '0;
        jmp_valid = 1'b0;
        jmp_cond = '0;
        jmp_base = '0;
        jmp_off = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R4: reset state
        check({flag_eq, flag_gt, flag_lt} === 3'b000, "R4 flags",
              {29'd0, flag_eq, flag_gt, flag_lt}, 32'd0);
        for (int cc = 0; cc < 8; cc++) begin
            jump_check(cc, (cc == 0 || cc == 2), "R4 cond after reset");
        end

        // R1 R2 R5 R6: table walk over all codes
        for (int i = 0; i < NVEC; i++) begin
            jmp_valid = 1'b0;
            do_cmp(VEC[i][66:35], VEC[i][34:3]);
            #1;
            check({flag_eq, flag_gt, flag_lt} === VEC[i][2:0], "R1 R2 flags",
                  {29'd0, flag_eq, flag_gt, flag_lt}, {29'd0, VEC[i][2:0]});
            for (int cc = 0; cc < 8; cc++) begin
                jump_check(cc, model_taken(VEC[i][2:0], cc),
                           cc == 7 ? "R6 reserved" : "R5 cond");
            end
        end

        // R7: no strobe, no taken
        jmp_valid = 1'b0;
        jmp_cond  = 3'd0;
        #1;
        check(jmp_taken === 1'b0, "R7 idle", {31'd0, jmp_taken}, 32'd0);

        // R3: flags hold across many jumps
        f_saved = {flag_eq, flag_gt, flag_lt};
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            jmp_valid = 1'b1;
            jmp_cond  = k[2:0];
        end
        @(negedge clk);
        jmp_valid = 1'b0;
        #1;
        check({flag_eq, flag_gt, flag_lt} === f_saved, "R3 hold",
              {29'd0, flag_eq, flag_gt, flag_lt}, {29'd0, f_saved});

        // R7: jump concurrent with compare sees old flags
        do_cmp(32'd3, 32'd3);
        cmp_valid = 1'b1;
        cmp_a = 32'd1;
        cmp_b = 32'd2;
        jump_check(1, 1'b1, "R7 same cycle eq old");
        jump_check(5, 1'b0, "R7 same cycle lt old");
        @(negedge clk);
        cmp_valid = 1'b0;
        jmp_valid = 1'b0;
        #1;
        check({flag_eq, flag_gt, flag_lt} === 3'b001, "R1 new flags",
              {29'd0, flag_eq, flag_gt, flag_lt}, 32'd1);

        // R8: target calculation
        jmp_base = 32'h0000_1000; jmp_off = 16'hFFF8; #1;
        check(jmp_target === 32'h0000_0FF8, "R8 negative off", jmp_target, 32'h0000_0FF8);
        jmp_base = 32'd0; jmp_off = 16'h7FFF; #1;
        check(jmp_target === 32'h0000_7FFF, "R8 absolute max", jmp_target, 32'h0000_7FFF);
        jmp_base = 32'd0; jmp_off = 16'h8000; #1;
        check(jmp_target === 32'hFFFF_8000, "R8 absolute min", jmp_target, 32'hFFFF_8000);
        jmp_base = 32'hFFFF_FFFF; jmp_off = 16'h0001; #1;
        check(jmp_target === 32'h0000_0000, "R8 wrap", jmp_target, 32'h0000_0000);
        jmp_base = 32'h1234_5678; jmp_off = 16'h0010; #1;
        check(jmp_target === 32'h1234_5688, "R8 positive off", jmp_target, 32'h1234_5688);

        // R4: reset after activity clears flags
        do_cmp(32'd8, 32'd2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check({flag_eq, flag_gt, flag_lt} === 3'b000, "R4 re-reset",
              {29'd0, flag_eq, flag_gt, flag_lt}, 32'd0);
        jump_check(3, 1'b0, "R4 gt after reset");
        jump_check(2, 1'b1, "R4 ne after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule